// File: doc/BRIEF.md
# Triggered Serial Attribute Encoder

This block lives on each remote unit. It holds a small set of attribute bits, each set by a strap, and sends them out as a single serial burst after a trigger pulse. A free-running bit-clock strobe sets the bit timing. A window opens on the trigger and passes that strobe to a one-hot ring counter, which steers one strap bit at a time onto the serial line. The window closes as soon as the frame has been sent, so each trigger produces exactly one frame.

Each word is six bits long. The unit can send either one word or all of its configured words back to back. A mode input is captured when the trigger arrives and selects between the two. The serial line stays low whenever no frame is in progress. A busy output covers the whole frame, and any trigger that arrives while busy is high is discarded.

Top module: `attr_serial_enc`

## Requirements
- R1: After reset, ser_o and busy_o are both low.
- R2: A one-cycle trig_i high while busy_o is low makes busy_o high on the next clock cycle.
- R3: Once busy_o is high, each tick_i pulse sends the next bit. ser_o takes that bit in the cycle after the tick and holds it until the next tick. Within a word the bits go out in the order 0, 1, 2, 3, 4, 5.
- R4: Word w, bit i is taken from strap_i[w*6+i]. A connected strap (1) drives ser_o high and an open strap (0) drives it low.
- R5: In single-word mode (multi_i low at the trigger), only word 0 is sent. The seventh tick of the frame drives ser_o and busy_o low in the cycle that follows it.
- R6: In multi-word mode (multi_i high at the trigger), all WORDS words are sent, starting with word 0. That is 6*WORDS bits, followed by one more tick that ends the frame.
- R7: While busy_o is high, trig_i has no effect. This includes a trigger in the same cycle as the tick that ends the frame, after which busy_o stays low.
- R8: multi_i is sampled only when a trigger is accepted. Changing it during a frame does not change the length of that frame.
- R9: While busy_o is low, tick_i pulses have no effect, and ser_o stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Start pulse, one cycle wide |
| tick_i | input | 1 | Free-running bit-clock strobe, one cycle wide |
| multi_i | input | 1 | 1 selects all words, 0 selects word 0 only; sampled at the trigger |
| strap_i | input | WORDS*6 | Attribute straps; bit w*6+i is word w, bit i |
| ser_o | output | 1 | Serial attribute output, low when idle |
| busy_o | output | 1 | High for the whole frame |

## Verification
Two events can land in the same clock edge. One is a trigger. The other is a bit-clock tick, either the tick that moves the frame along or the tick that closes the window. The bench raises trig_i together with a mid-frame tick and again together with the closing tick. It then checks that the remaining bits still follow the strap pattern in order and that busy_o drops and stays low. A further case sets up a mode change in the middle of a frame, and the bench checks that the frame length still matches the mode captured at the trigger.

// File: rtl/attr_enc_pkg.sv
package attr_enc_pkg;
  localparam int unsigned WORD_BITS = 6;

  function automatic logic [WORD_BITS-1:0] rot_left(input logic [WORD_BITS-1:0] v);
    return {v[WORD_BITS-2:0], v[WORD_BITS-1]};
  endfunction
endpackage

// File: rtl/attr_gate.sv
module attr_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic tick_i,
  input  logic last_i,
  input  logic mode_i,
  output logic busy_o,
  output logic adv_o,
  output logic close_o,
  output logic mode_o
);
  logic open_q, tail_q, mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      tail_q <= 1'b0;
      mode_q <= 1'b0;
    end else if (!open_q) begin
      if (trig_i) begin
        open_q <= 1'b1;
        tail_q <= 1'b0;
        mode_q <= mode_i;
      end
    end else if (tick_i) begin
      if (tail_q) begin
        open_q <= 1'b0;
        tail_q <= 1'b0;
      end else if (last_i) begin
        tail_q <= 1'b1;  // final bit leaves now; next tick closes
      end
    end
  end

  assign busy_o  = open_q;
  assign adv_o   = open_q & tick_i & ~tail_q;
  assign close_o = open_q & tick_i & tail_q;
  assign mode_o  = mode_q;

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_q && trig_i |=> open_q);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_q && !tick_i |=> open_q && $stable(mode_q));
  p_close_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_o |=> !open_q);
  p_idle_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_q && !trig_i |=> !open_q);
endmodule

// File: rtl/attr_ring.sv
module attr_ring
  import attr_enc_pkg::*;
#(
  parameter int unsigned WORDS = 3,
  parameter int unsigned WW    = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 adv_i,
  input  logic                 clr_i,
  input  logic                 mode_i,
  output logic [WORD_BITS-1:0] ring_o,
  output logic [WW-1:0]        word_o,
  output logic                 last_o
);
  localparam logic [WW-1:0] LAST_WORD = WW'(WORDS - 1);

  logic [WORD_BITS-1:0] ring_q;
  logic [WW-1:0]        word_q;
  logic [WW-1:0]        last_idx;

  assign last_idx = mode_i ? LAST_WORD : '0;
  assign last_o   = ring_q[WORD_BITS-1] && (word_q == last_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ring_q <= WORD_BITS'(1);
      word_q <= '0;
    end else if (clr_i) begin
      ring_q <= WORD_BITS'(1);
      word_q <= '0;
    end else if (adv_i) begin
      ring_q <= rot_left(ring_q);
      if (ring_q[WORD_BITS-1]) word_q <= last_o ? '0 : word_q + WW'(1);
    end
  end

  assign ring_o = ring_q;
  assign word_o = word_q;

  p_ring_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ring_q) == 1);
  p_word_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_q <= LAST_WORD);
  p_ring_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i && !clr_i |=> $stable(ring_q) && $stable(word_q));
endmodule

// File: rtl/attr_sel.sv
module attr_sel
  import attr_enc_pkg::*;
#(
  parameter int unsigned WORDS = 3,
  parameter int unsigned WW    = 2
) (
  input  logic [WORDS*WORD_BITS-1:0] strap_i,
  input  logic [WORD_BITS-1:0]       ring_i,
  input  logic [WW-1:0]              word_i,
  output logic                       bit_o
);
  logic [WORD_BITS-1:0] word_bits [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign word_bits[w] = strap_i[w*WORD_BITS +: WORD_BITS];
  end

  always_comb begin
    bit_o = 1'b0;
    for (int w = 0; w < WORDS; w++) begin
      if (word_i == WW'(w)) bit_o = |(word_bits[w] & ring_i);
    end
  end
endmodule

// File: rtl/attr_serial_enc.sv
module attr_serial_enc
  import attr_enc_pkg::*;
#(
  parameter int unsigned WORDS = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       trig_i,
  input  logic                       tick_i,
  input  logic                       multi_i,
  input  logic [WORDS*WORD_BITS-1:0] strap_i,
  output logic                       ser_o,
  output logic                       busy_o
);
  localparam int unsigned WW = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic                 busy, adv, close_w, mode_q, last_w, bit_w;
  logic [WORD_BITS-1:0] ring;
  logic [WW-1:0]        word;
  logic                 ser_q;

  attr_gate u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (trig_i),
    .tick_i  (tick_i),
    .last_i  (last_w),
    .mode_i  (multi_i),
    .busy_o  (busy),
    .adv_o   (adv),
    .close_o (close_w),
    .mode_o  (mode_q)
  );

  attr_ring #(.WORDS(WORDS), .WW(WW)) u_ring (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv),
    .clr_i  (~busy),
    .mode_i (mode_q),
    .ring_o (ring),
    .word_o (word),
    .last_o (last_w)
  );

  attr_sel #(.WORDS(WORDS), .WW(WW)) u_sel (
    .strap_i (strap_i),
    .ring_i  (ring),
    .word_i  (word),
    .bit_o   (bit_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ser_q <= 1'b0;
    else if (close_w) ser_q <= 1'b0;
    else if (adv)     ser_q <= bit_w;
  end

  assign ser_o  = ser_q;
  assign busy_o = busy;

  p_idle_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !ser_o);
  p_ser_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(ser_o));
endmodule

// File: tb/attr_serial_enc_bench.sv
module attr_serial_enc_bench;
  localparam int unsigned WORDS = 3;
  localparam int unsigned NB    = WORDS * 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trig = 1'b0, tick = 1'b0, multi = 1'b0;
  logic [NB-1:0] strap = '0;
  logic          ser, busy;
  int            checks = 0, errors = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  attr_serial_enc #(.WORDS(WORDS)) u_attr_serial_enc (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .tick_i(tick),
    .multi_i(multi), .strap_i(strap), .ser_o(ser), .busy_o(busy)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // mode_at: multi_i at trigger; mode_mid: value during frame; retrig: collide triggers
  task automatic run_frame(input logic mode_at, input logic mode_mid, input bit retrig);
    int nb;
    nb = mode_at ? NB : 6;
    trig = 1'b1; multi = mode_at;
    @(negedge clk);
    trig = 1'b0; multi = mode_mid;
    chk("R2", "busy after trigger", busy, 1'b1);
    chk("R9", "ser before first tick", ser, 1'b0);
    for (int k = 0; k < nb; k++) begin
      tick = 1'b1; trig = retrig && (k == 2);
      @(negedge clk);
      tick = 1'b0; trig = 1'b0;
      chk(mode_at ? "R6" : "R4", $sformatf("bit %0d", k), ser, strap[k]);
      chk("R3", $sformatf("busy at bit %0d", k), busy, 1'b1);
      @(negedge clk);
      chk("R3", $sformatf("hold bit %0d", k), ser, strap[k]);
    end
    tick = 1'b1; trig = retrig;
    @(negedge clk);
    tick = 1'b0; trig = 1'b0;
    chk("R5", "ser after closing tick", ser, 1'b0);
    chk("R5", "busy after closing tick", busy, 1'b0);
    @(negedge clk);
    chk("R7", "busy stays low after collision", busy, 1'b0);
    multi = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "ser in reset", ser, 1'b0);
    chk("R1", "busy in reset", busy, 1'b0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk("R1", "ser after reset", ser, 1'b0);
    chk("R1", "busy after reset", busy, 1'b0);
  endtask

  task automatic t_idle_ticks();
    strap = '1;
    for (int k = 0; k < 4; k++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0;
      chk("R9", "ser on idle tick", ser, 1'b0);
      chk("R9", "busy on idle tick", busy, 1'b0);
    end
  endtask

  task automatic t_single();
    strap = 18'h2_D_A5; run_frame(1'b0, 1'b0, 1'b0);  // R4 R5
    strap = 18'h3_F_C_21 & 18'h3FFFF; run_frame(1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_multi();
    strap = 18'h1_B_6_9 & 18'h3FFFF; run_frame(1'b1, 1'b1, 1'b0);  // R6
    strap = 18'h2_A_A_A & 18'h3FFFF; run_frame(1'b1, 1'b0, 1'b0);  // R8 high->low
  endtask

  task automatic t_retrig();
    strap = 18'h0_5_3_C & 18'h3FFFF; run_frame(1'b0, 1'b0, 1'b1);  // R7
    strap = 18'h3_0_F_0 & 18'h3FFFF; run_frame(1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_mode_latch();
    strap = 18'h3_F_F_F & 18'h3FFFF; run_frame(1'b0, 1'b1, 1'b0);  // R8 low->high
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle_ticks();
    t_single();
    t_multi();
    t_retrig();
    t_mode_latch();
    t_idle_ticks();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule